// File: doc/BRIEF.md
# Free-Running Watchdog with Edge-Gated Reset

This block is a watchdog countdown timer that cannot be halted. An 8-bit preset sets the timeout as a number of units. A control bit picks whether one unit is one second or one minute. A tick prescaler derives both units from the clock frequency.

Software keeps the system alive by writing the preset again, which reloads the count and restarts the countdown. When the count runs out, a sticky event flag sets and the counter reloads from the preset, so it keeps running. Writing one to the flag clears it.

A system reset pulse is produced only at the moment the event flag goes from clear to set, and only if output enable is set at that moment. "Stopping" the watchdog therefore means clearing output enable; the count itself never stops. The registers are reached through a plain single-cycle write strobe and a combinational read port. Any bus bridge sits outside the block.

Top module: `alive_wdt`

## Requirements
- R1: After reset the preset (address 0) reads 0xFF, and control (address 1), output enable (address 2) and event (address 3) read 0x00. `sys_rst_o` is low.
- R2: The countdown runs whatever output enable holds. With output enable clear, expiry still sets the event flag. The counter then reloads from the preset and keeps counting.
- R3: Writing the preset register reloads the counter and restarts the prescaler. In seconds mode, expiry takes effect on the clock edge that comes preset × CYC_PER_SEC cycles after the write edge. Expiry that was due before the rewrite does not occur.
- R4: Control bit 0 selects the unit: 1 gives seconds, 0 gives minutes. A minute is SEC_PER_MIN seconds, so minute-mode expiry comes preset × CYC_PER_SEC × SEC_PER_MIN cycles after the preset write.
- R5: When the event flag (bit 0 at address 3) rises while output enable bit 1 (address 2) is set, `sys_rst_o` goes high on that same edge.
- R6: Setting output enable while the event flag is already set produces no reset pulse.
- R7: A further expiry while the event flag is still set produces no reset pulse.
- R8: The reset pulse stays high for exactly RST_PULSE_W cycles.
- R9: Writing 1 to bit 0 of the event register clears the flag. Writing 0 to bit 0 leaves it unchanged. If expiry and clear fall in the same cycle, the flag is set.
- R10: A preset value of 0 behaves as a preset of 1.
- R11: Control reads back only bit 0, and output enable reads back only bit 1. All other bits read 0. The preset reads back all 8 bits. The remaining count cannot be read.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 2 | Register address: 0 preset, 1 control, 2 output enable, 3 event |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The bench places checks on the cycle before and the cycle of each expiry. This exposes a counter that is off by one, or that fails to restart its prescaler on a preset write (a kick would then land late or early). It enables output after an expiry and lets a second expiry pass while the flag stays set. A design that gates the reset on the flag's level rather than its rising edge would pulse in both cases. It also writes zeros and a cleared bit 0 to the event register, where a plain-write or level-cleared flag would drop. Finally, it uses a zero preset, which would otherwise wrap to a 256-unit timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    REG_PRESET = 2'd0,
    REG_CTRL   = 2'd1,
    REG_OUTEN  = 2'd2,
    REG_EVENT  = 2'd3
  } wdt_reg_e;

  localparam int unsigned CTRL_SEC_BIT = 0;
  localparam int unsigned OUTEN_BIT    = 1;
  localparam int unsigned EVENT_BIT    = 0;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned CYC_PER_SEC = 32768,
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic sec_tick_o,
  output logic min_tick_o
);
  localparam int unsigned CYC_W = $clog2(CYC_PER_SEC + 1);
  localparam int unsigned SEC_W = $clog2(SEC_PER_MIN + 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_SEC - 1);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [SEC_W-1:0] sec_q;

  assign sec_tick_o = (cyc_q == CYC_LAST);
  assign min_tick_o = sec_tick_o && (sec_q == SEC_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      sec_q <= '0;
    end else if (restart_i) begin
      cyc_q <= '0;
      sec_q <= '0;
    end else if (sec_tick_o) begin
      cyc_q <= '0;
      sec_q <= min_tick_o ? '0 : sec_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int unsigned          CNT_W   = 8,
  parameter logic [CNT_W-1:0]     RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign expire_o = tick_i && !load_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= floor_one(RST_VAL);
    else if (load_i)   cnt_q <= floor_one(load_val_i);
    else if (expire_o) cnt_q <= floor_one(reload_val_i);
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int unsigned PULSE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned PW_W = $clog2(PULSE_W + 1);

  logic [PW_W-1:0] left_q;

  assign pulse_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      left_q <= '0;
    else if (trig_i)  left_q <= PW_W'(PULSE_W);
    else if (pulse_o) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/alive_wdt.sv
module alive_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CYC_PER_SEC = 32768,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned RST_PULSE_W = 4,
  parameter logic [7:0]  PRESET_RST  = 8'hFF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       sys_rst_o
);
  logic [7:0] preset_q;
  logic       sec_mode_q;
  logic       outen_q;
  logic       event_q;

  logic wr_preset, wr_ctrl, wr_outen, evt_clear;
  logic sec_tick, min_tick, unit_tick, expire, rst_trig;

  assign wr_preset = wr_en_i && (addr_i == REG_PRESET);
  assign wr_ctrl   = wr_en_i && (addr_i == REG_CTRL);
  assign wr_outen  = wr_en_i && (addr_i == REG_OUTEN);
  assign evt_clear = wr_en_i && (addr_i == REG_EVENT) && wdata_i[EVENT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preset_q   <= PRESET_RST;
      sec_mode_q <= 1'b0;
      outen_q    <= 1'b0;
    end else begin
      if (wr_preset) preset_q   <= wdata_i;
      if (wr_ctrl)   sec_mode_q <= wdata_i[CTRL_SEC_BIT];
      if (wr_outen)  outen_q    <= wdata_i[OUTEN_BIT];
    end
  end

  wdt_tick_gen #(
    .CYC_PER_SEC (CYC_PER_SEC),
    .SEC_PER_MIN (SEC_PER_MIN)
  ) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (wr_preset),
    .sec_tick_o (sec_tick),
    .min_tick_o (min_tick)
  );

  assign unit_tick = sec_mode_q ? sec_tick : min_tick;

  wdt_down_cnt #(
    .CNT_W   (8),
    .RST_VAL (PRESET_RST)
  ) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (wr_preset),
    .load_val_i   (wdata_i),
    .reload_val_i (preset_q),
    .tick_i       (unit_tick),
    .expire_o     (expire)
  );

  // Set wins over a same-cycle clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        event_q <= 1'b0;
    else if (expire)    event_q <= 1'b1;
    else if (evt_clear) event_q <= 1'b0;
  end

  // Reset fires only on the 0->1 flank of the flag.
  assign rst_trig = expire && !event_q && outen_q;

  wdt_rst_pulse #(
    .PULSE_W (RST_PULSE_W)
  ) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (rst_trig),
    .pulse_o (sys_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_PRESET: rdata_o = preset_q;
      REG_CTRL:   rdata_o[CTRL_SEC_BIT] = sec_mode_q;
      REG_OUTEN:  rdata_o[OUTEN_BIT]    = outen_q;
      REG_EVENT:  rdata_o[EVENT_BIT]    = event_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/alive_wdt_chk.sv
module alive_wdt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       sys_rst_o,
  input logic       event_q,
  input logic       outen_q,
  input logic       expire
);
  a_r5_rst_on_flag_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $rose(event_q));

  a_r6_rst_needs_outen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(outen_q));

  a_r7_no_rst_while_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_q && expire) |=> !$rose(sys_rst_o));

  a_r9_event_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_q && !(wr_en_i && addr_i == 2'd3 && wdata_i[0])) |=> event_q);

  a_r2_expiry_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> event_q);
endmodule

bind alive_wdt alive_wdt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .sys_rst_o (sys_rst_o),
  .event_q   (event_q),
  .outen_q   (outen_q),
  .expire    (expire)
);

// File: tb/alive_wdt_bench.sv
`timescale 1ns/1ps
module alive_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 4;
  localparam int M  = 3;
  localparam int PW = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       sys_rst_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alive_wdt #(
    .CYC_PER_SEC (T),
    .SEC_PER_MIN (M),
    .RST_PULSE_W (PW),
    .PRESET_RST  (8'hFF)
  ) u_alive_wdt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .sys_rst_o (sys_rst_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; consumes one clock edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic ev_is(input logic e, input string req);
    logic [7:0] d;
    rd(2'd3, d);
    chk(d == {7'd0, e}, req, d, {7'd0, e});
  endtask

  task automatic rst_is(input logic v, input string req);
    chk(sys_rst_o == v, req, sys_rst_o, v);
  endtask

  // Preset write edge E; returns at E+2.5 after clearing event and setting output enable.
  task automatic setup(input logic sec, input logic [7:0] p, input logic oe);
    wr(2'd2, 8'h00);
    wr(2'd1, {7'd0, sec});
    wr(2'd0, p);
    wr(2'd3, 8'h01);
    wr(2'd2, {6'd0, oe, 1'b0});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk(d == 8'hFF, "R1 preset", d, 8'hFF);
    rd(2'd1, d); chk(d == 8'h00, "R1 ctrl", d, 0);
    rd(2'd2, d); chk(d == 8'h00, "R1 outen", d, 0);
    ev_is(1'b0, "R1 event");
    rst_is(1'b0, "R1 sys_rst");
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(2'd1, 8'hFF); rd(2'd1, d); chk(d == 8'h01, "R11 ctrl mask", d, 8'h01);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk(d == 8'h02, "R11 outen mask", d, 8'h02);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hA5); rd(2'd0, d); chk(d == 8'hA5, "R11 preset", d, 8'hA5);
  endtask

  task automatic t_sec_expiry();
    setup(1'b1, 8'd3, 1'b1);
    repeat (3*T - 3) @(negedge clk_i);
    ev_is(1'b0, "R3 no early expiry");
    rst_is(1'b0, "R5 no early reset");
    @(negedge clk_i);
    ev_is(1'b1, "R3 expiry at preset*T");
    rst_is(1'b1, "R5 reset on flag rise");
    repeat (PW - 1) @(negedge clk_i);
    rst_is(1'b1, "R8 pulse last cycle");
    @(negedge clk_i);
    rst_is(1'b0, "R8 pulse ended");
  endtask

  task automatic t_w1c();
    wr(2'd3, 8'h00);  ev_is(1'b1, "R9 write 0 keeps flag");
    wr(2'd3, 8'hFE);  ev_is(1'b1, "R9 bit0 clear keeps flag");
    wr(2'd3, 8'h01);  ev_is(1'b0, "R9 write 1 clears");
  endtask

  task automatic t_kick();
    setup(1'b1, 8'd3, 1'b1);
    repeat (7) @(negedge clk_i);
    wr(2'd0, 8'd3);
    repeat (10) @(negedge clk_i);
    ev_is(1'b0, "R3 kick cancels old expiry");
    rst_is(1'b0, "R3 kick no reset");
    @(negedge clk_i);
    ev_is(1'b0, "R3 kick no early expiry");
    @(negedge clk_i);
    ev_is(1'b1, "R3 expiry after kick");
    rst_is(1'b1, "R5 reset after kick");
    repeat (PW + 1) @(negedge clk_i);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_min_gate();
    int hits = 0;
    setup(1'b0, 8'd2, 1'b0);
    repeat (2*T*M - 3) @(negedge clk_i);
    ev_is(1'b0, "R4 no early minute expiry");
    @(negedge clk_i);
    ev_is(1'b1, "R4 minute expiry; R2 runs with outen clear");
    rst_is(1'b0, "R2 no reset with outen clear");
    wr(2'd2, 8'h02);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (sys_rst_o) hits++;
    end
    chk(hits == 0, "R6 R7 late enable and re-expiry give no reset", hits, 0);
    ev_is(1'b1, "R2 flag stays set");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_zero_preset();
    setup(1'b1, 8'd0, 1'b1);
    repeat (T - 3) @(negedge clk_i);
    ev_is(1'b0, "R10 zero preset not early");
    @(negedge clk_i);
    ev_is(1'b1, "R10 zero preset acts as 1");
    rst_is(1'b1, "R10 reset on zero preset");
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 5);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_readback();
        t_sec_expiry();
        t_w1c();
        t_kick();
        t_min_gate();
        t_zero_preset();
      end
      begin
        #(CLK_PERIOD * 20000);
        chk(1'b0, "watchdog timeout", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule